// File: doc/BRIEF.md
# Exponential Ramp PWM Generator

The block drives a fixed-frequency PWM output whose duty cycle climbs from 0% to 100% along a curve that approximates an exponential settling shape. A free-running period counter sets the PWM frequency and emits one pulse at the last clock of every period. A postscale counter counts those pulses. Each time it rolls over, the 8-bit duty value rises by exactly one, and the new value is used from the next period on.

The postscale factor starts at 1 and doubles after every fixed number of PWM periods, up to a configurable ceiling (128 by default). Duty steps therefore come less and less often. The ramp is a chain of linear segments, each half as steep as the one before. Once the duty value reaches 255 the output stays high, a done flag is raised and held, and every counter freezes. A single-cycle start pulse restarts the ramp from zero at any time, including in the middle of a ramp or after it has finished.

Top module: `exp_ramp_pwm`

## Requirements
- R1: After reset and before the first start pulse, `pwm_o` and `done_o` are both low, and the duty value does not advance.
- R2: In every PWM period of `PERIOD` clocks with duty value d, `pwm_o` is high for the first floor(d*PERIOD/256) clocks and low for the rest. At d = 255, `pwm_o` is high for the whole period.
- R3: The duty value is 0 in the first period after a start pulse. It increases by exactly 1 each time the postscale counter rolls over, and at no other time.
- R4: The postscale factor is 1 for the first `SEG_LEN` periods after start. It doubles after every further `SEG_LEN` periods and stops doubling at 2^`MAX_SHIFT`. A rollover happens after a number of period ends equal to the factor in force.
- R5: The duty value changes only at the end of a period. Within one period the high clocks form a single run that starts at the first clock of the period.
- R6: When the duty value reaches 255, `done_o` rises together with it and stays high until the next start pulse. The duty, postscale and segment counters stop.
- R7: A start pulse, sampled on a clock edge, makes the next clock the first clock of a new period with duty 0, `done_o` low and postscale factor 1. This holds whether or not a ramp is in progress.
- R8: The postscale and segment counters change only on the clock that ends a PWM period, or on a start pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock; PWM counting runs on it |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Single-cycle pulse that restarts the ramp from zero |
| pwm_o | output | 1 | PWM output |
| done_o | output | 1 | High once the duty value has saturated at 255 |

## Verification
On every cycle the assertions check four things. The duty value moves only on a rollover step. The postscale and segment counters move only on a period-end pulse. The postscale exponent never skips a value or passes its ceiling. The done flag is held and forces a full-high output. Only the bench scenarios can show the shape of the whole ramp: the exact period in which each duty step appears at the output, the doubling of the step interval at each segment boundary, and where saturation falls. They also show that a restart in the middle of a ramp returns the output to zero duty within one period.

// File: rtl/exr_pkg.sv
package exr_pkg;
   localparam int DUTY_W = 8;
   typedef logic [DUTY_W-1:0] duty_t;
   localparam duty_t DUTY_MAX = '1;
endpackage

// File: rtl/exr_period_gen.sv
module exr_period_gen #(
   parameter int PERIOD = 256
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic                      restart_i,
   output logic [$clog2(PERIOD)-1:0] pcnt_o,
   output logic                      match_o
);
   localparam int PCW = $clog2(PERIOD);
   localparam logic [PCW-1:0] LAST = PCW'(PERIOD - 1);

   logic [PCW-1:0] cnt_q;

   generate
      if (PERIOD < 2) begin : g_bad_period
         $error("exr_period_gen: PERIOD must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            cnt_q <= '0;
      else if (restart_i)     cnt_q <= '0;
      else if (cnt_q == LAST) cnt_q <= '0;
      else                    cnt_q <= cnt_q + 1'b1;
   end

   assign pcnt_o  = cnt_q;
   assign match_o = (cnt_q == LAST);

   // R5: every period end or restart is followed by the first clock of a period
   a_r5_period_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (match_o || restart_i) |=> (pcnt_o == '0));
endmodule

// File: rtl/exr_postscaler.sv
module exr_postscaler #(
   parameter int SEG_LEN   = 140,
   parameter int MAX_SHIFT = 7
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic restart_i,
   input  logic match_i,
   input  logic hold_i,
   output logic step_o
);
   localparam int PSW = MAX_SHIFT + 1;
   localparam int SGW = $clog2(SEG_LEN + 1);
   localparam int SHW = $clog2(MAX_SHIFT + 2);
   localparam logic [SGW-1:0] SEG_LAST = SGW'(SEG_LEN - 1);
   localparam logic [SHW-1:0] SH_TOP   = SHW'(MAX_SHIFT);

   generate
      if (SEG_LEN < 1) begin : g_bad_seg
         $error("exr_postscaler: SEG_LEN must be at least 1");
      end
      if (MAX_SHIFT < 0 || MAX_SHIFT > 15) begin : g_bad_shift
         $error("exr_postscaler: MAX_SHIFT must lie in 0..15");
      end
   endgenerate

   logic           run_q;
   logic [PSW-1:0] psc_q;
   logic [SGW-1:0] seg_q;
   logic [SHW-1:0] shift_q;
   logic [PSW-1:0] fmask;
   logic           en;
   logic           seg_wrap;

   always_comb begin
      for (int i = 0; i < PSW; i++) begin
         fmask[i] = (SHW'(i) < shift_q);
      end
   end

   assign en       = match_i && run_q && !hold_i;
   assign step_o   = en && (psc_q == fmask);
   assign seg_wrap = (seg_q == SEG_LAST);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q   <= 1'b0;
         psc_q   <= '0;
         seg_q   <= '0;
         shift_q <= '0;
      end else if (restart_i) begin
         run_q   <= 1'b1;
         psc_q   <= '0;
         seg_q   <= '0;
         shift_q <= '0;
      end else if (en) begin
         psc_q <= step_o ? '0 : psc_q + 1'b1;
         if (seg_wrap) begin
            seg_q <= '0;
            if (shift_q < SH_TOP) shift_q <= shift_q + 1'b1;
         end else begin
            seg_q <= seg_q + 1'b1;
         end
      end
   end

   // R8: counters advance only on a period-end pulse
   a_r8_count_on_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!match_i && !restart_i) |=> ($stable(psc_q) && $stable(seg_q)));
   // R6: counting is frozen once the ramp has saturated
   a_r6_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hold_i && !restart_i) |=> ($stable(psc_q) && $stable(shift_q)));
   // R4: the exponent only holds or rises by one, and never passes its ceiling
   a_r4_no_skip: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !restart_i |=> ((shift_q == $past(shift_q)) ||
                      (shift_q == $past(shift_q) + SHW'(1))));
   a_r4_ceiling: assert property (@(posedge clk_i) disable iff (!rst_ni)
      shift_q <= SH_TOP);
endmodule

// File: rtl/exr_duty.sv
module exr_duty
   import exr_pkg::*;
#(
   parameter int PERIOD = 256
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic                      restart_i,
   input  logic                      step_i,
   input  logic [$clog2(PERIOD)-1:0] pcnt_i,
   output logic                      pwm_o,
   output logic                      done_o
);
   localparam int PCW = $clog2(PERIOD);
   localparam int PRW = DUTY_W + PCW + 1;

   duty_t          duty_q;
   logic           done_q;
   logic [PCW-1:0] thr;

   generate
      if (PERIOD == (1 << DUTY_W)) begin : g_thr_direct
         assign thr = duty_q;
      end else begin : g_thr_scaled
         logic [PRW-1:0] prod;
         assign prod = PRW'(duty_q) * PRW'(PERIOD);
         assign thr  = prod[PCW+DUTY_W-1:DUTY_W];
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         duty_q <= '0;
         done_q <= 1'b0;
      end else if (restart_i) begin
         duty_q <= '0;
         done_q <= 1'b0;
      end else if (step_i && duty_q != DUTY_MAX) begin
         duty_q <= duty_q + 1'b1;
         if (duty_q == DUTY_MAX - 1'b1) done_q <= 1'b1;
      end
   end

   assign pwm_o  = (duty_q == DUTY_MAX) || (pcnt_i < thr);
   assign done_o = done_q;

   // R5: the duty value moves only on a rollover step
   a_r5_duty_on_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!step_i && !restart_i) |=> $stable(duty_q));
   // R6: done is held until restart
   a_r6_done_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_q && !restart_i) |=> done_q);
   // R2: saturated ramp keeps the output high
   a_r2_full_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> pwm_o);
endmodule

// File: rtl/exp_ramp_pwm.sv
module exp_ramp_pwm #(
   parameter int PERIOD    = 68670,
   parameter int SEG_LEN   = 140,
   parameter int MAX_SHIFT = 7
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   output logic pwm_o,
   output logic done_o
);
   localparam int PCW = $clog2(PERIOD);

   logic [PCW-1:0] pcnt;
   logic           match;
   logic           step;

   exr_period_gen #(.PERIOD(PERIOD)) i_period (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .restart_i (start_i),
      .pcnt_o    (pcnt),
      .match_o   (match)
   );

   exr_postscaler #(.SEG_LEN(SEG_LEN), .MAX_SHIFT(MAX_SHIFT)) i_post (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .restart_i (start_i),
      .match_i   (match),
      .hold_i    (done_o),
      .step_o    (step)
   );

   exr_duty #(.PERIOD(PERIOD)) i_duty (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .restart_i (start_i),
      .step_i    (step),
      .pcnt_i    (pcnt),
      .pwm_o     (pwm_o),
      .done_o    (done_o)
   );

   // R1: nothing is output before the first start
   a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!done_o && !pwm_o && !start_i && !step) |=> !done_o);
endmodule

// File: tb/test_exp_ramp_pwm.sv
`timescale 1ns/1ps
module test_exp_ramp_pwm;
   localparam int P     = 64;
   localparam int SEG   = 24;
   localparam int MAXSH = 3;

   typedef struct {
      int    hi;
      bit    dn;
      string req;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic pwm, done;
   int   n_tests = 0;
   int   n_fail  = 0;
   bit   finished = 1'b0;
   exp_t sb_q[$];

   always #2.5 clk = ~clk;

   exp_ramp_pwm #(.PERIOD(P), .SEG_LEN(SEG), .MAX_SHIFT(MAXSH)) i_exp_ramp_pwm (
      .clk_i   (clk),
      .rst_ni  (rst_n),
      .start_i (start),
      .pwm_o   (pwm),
      .done_o  (done)
   );

   task automatic check(input bit ok, input string req, input int act, input int expv);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, expv);
      end
   endtask

   // driver: reference ramp model, pushes expected per-period items
   task automatic drive_expect(input int max_periods, input int extra_after_done);
      int d = 0, psc = 0, seg = 0, sh = 0, tail = 0;
      bit dn = 1'b0;
      for (int k = 0; k < max_periods; k++) begin
         exp_t it;
         it.hi = (d == 255) ? P : (d * P) / 256;
         it.dn = dn;
         if (k < 3)      it.req = "R7";
         else if (dn)    it.req = "R6";
         else if (sh == 0) it.req = "R2,R3";
         else            it.req = "R4,R8";
         sb_q.push_back(it);
         if (dn) begin
            tail++;
            if (tail >= extra_after_done) break;
         end else begin
            if (psc == (1 << sh) - 1) begin
               psc = 0;
               d++;
               if (d == 255) dn = 1'b1;
            end else begin
               psc++;
            end
            if (seg == SEG - 1) begin
               seg = 0;
               if (sh < MAXSH) sh++;
            end else begin
               seg++;
            end
         end
      end
   endtask

   task automatic pulse_start();
      @(negedge clk) start = 1'b1;
      @(posedge clk);
      #1 start = 1'b0;
   endtask

   // monitor: pops one expected item per observed period
   task automatic monitor_run();
      while (sb_q.size() > 0) begin
         exp_t e;
         int hi = 0;
         bit fell = 1'b0, split = 1'b0, dn0 = 1'b0;
         e = sb_q.pop_front();
         for (int j = 0; j < P; j++) begin
            @(negedge clk);
            if (j == 0) dn0 = done;
            if (pwm) begin
               hi++;
               if (fell) split = 1'b1;
            end else begin
               fell = 1'b1;
            end
         end
         check(hi == e.hi, e.req, hi, e.hi);
         check(dn0 == e.dn, {e.req, " done"}, int'(dn0), int'(e.dn));
         check(!split, "R5 single high run", int'(split), 0);
      end
   endtask

   initial begin
      #(190000 * 5);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(pwm == 1'b0, "R1 pwm in reset", int'(pwm), 0);
      check(done == 1'b0, "R1 done in reset", int'(done), 0);
      rst_n = 1'b1;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         check(pwm == 1'b0 && done == 1'b0, "R1 idle before start",
               int'({pwm, done}), 0);
      end
      // partial ramp, then restart mid-ramp
      pulse_start();
      drive_expect(150, 1);
      monitor_run();
      pulse_start();
      drive_expect(4000, 6);
      monitor_run();
      // restart after saturation
      pulse_start();
      drive_expect(30, 1);
      monitor_run();
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule